// File: doc/BRIEF.md
# Checkpoint Dirty-Flag Grid with Newest-Table Search

This block sits beside the mapping tables of a checkpointed register renamer. It keeps one flag per pair of architectural register and checkpoint table. A flag that is set means that table holds a valid mapping for that register. When the renamer starts a new epoch it clears the column of the table it allocates. Each renamed destination then sets the flag in its register's row, in the column the head pointer selects.

A source lookup reads one row and walks the columns circularly, from the head table back toward the tail table. It reports the first set flag, which marks the newest table holding the register. If no flag in that window is set, the lookup reports a miss, and the caller falls back to the committed mapping. Three lookups run in parallel every cycle. Their results are combinational and reflect the flags as they stood before that cycle's updates.

The pointers come from outside. The block never moves them. Flags in columns outside the window from tail to head are ignored, so no clean-up is needed when pointers retreat or advance.

Top module: `dirty_flag_grid`

## Requirements
- R1: Reset clears every flag, so every lookup after reset reports a miss (lk_hit low) whatever head and tail are.
- R2: A set request (set_en high) marks the flag in row set_reg, column head. It becomes visible to lookups from the cycle after the request.
- R3: A clear request (clr_en high) zeroes every flag in column clr_tbl from the next cycle on. Flags in other columns keep their values.
- R4: A lookup returns lk_hit high and lk_tbl set to the newest table with a set flag in its row. Newest means fewest backward steps from head.
- R5: The backward scan wraps modulo the table count. With head 0 and tail 2 of 4 tables, the scan order is 0, 3, 2.
- R6: Only columns from tail to head inclusive, taken circularly, are searched. Set flags in other columns do not produce a hit.
- R7: When no flag in the active window of the row is set, lk_hit is low.
- R8: Three lookups with different register indices are answered independently in the same cycle.
- R9: If a clear and a set target the same column in one cycle, the column afterwards holds only the newly set flag.
- R10: Lookups in a cycle that carries a set or a clear return the flags from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| head | input | TBL_W (2) | Newest active table, the target column of set requests |
| tail | input | TBL_W (2) | Oldest active table |
| clr_en | input | 1 | Clear a whole column this cycle |
| clr_tbl | input | TBL_W (2) | Column to clear |
| set_en | input | 1 | Mark one flag in the head column this cycle |
| set_reg | input | REG_W (5) | Row to mark |
| lk_reg | input | NUM_LOOKUPS x REG_W (3x5) | Register index per lookup lane |
| lk_hit | output | NUM_LOOKUPS (3) | Lane found a set flag in the active window |
| lk_tbl | output | NUM_LOOKUPS x TBL_W (3x2) | Newest matching table per lane, valid when its hit is high |

## Verification
Lookup results are combinational from the flag registers, so they belong to the cycle in which the lookup indices are driven. A set or a clear shows in lookups only one rising edge later. The bench drives every input at the falling edge and samples the outputs one time unit afterwards, well before the next rising edge. A lookup issued alongside an update is therefore checked against the old flags, and the next vector is checked against the new ones. The vector table is built so that several rows depend on exactly this one-edge delay, including a stale flag that is still seen in the cycle its column is cleared.

// File: rtl/dfg_pkg.sv
package dfg_pkg;

    // Default geometry of the flag grid.
    localparam int DEF_REGS    = 32;
    localparam int DEF_TABLES  = 4;
    localparam int DEF_LOOKUPS = 3;

    // Number of columns walked from head back to tail, inclusive minus one.
    function automatic int window_span(input int hd, input int tl, input int ntab);
        return (hd >= tl) ? (hd - tl) : (hd + ntab - tl);
    endfunction

endpackage

// File: rtl/dfg_flag_store.sv
module dfg_flag_store
    import dfg_pkg::*;
#(
    parameter int NUM_REGS   = DEF_REGS,
    parameter int NUM_TABLES = DEF_TABLES,
    localparam int REG_W     = $clog2(NUM_REGS),
    localparam int TBL_W     = $clog2(NUM_TABLES)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [TBL_W-1:0]                      head,
    input  logic                                  clr_en,
    input  logic [TBL_W-1:0]                      clr_tbl,
    input  logic                                  set_en,
    input  logic [REG_W-1:0]                      set_reg,
    output logic [NUM_REGS-1:0][NUM_TABLES-1:0]   flags
);

    // One register vector per column; a column clears as a unit.
    for (genvar c = 0; c < NUM_TABLES; c++) begin : g_col
        logic [NUM_REGS-1:0] bits_q;
        logic [NUM_REGS-1:0] bits_d;
        logic                wipe;
        logic                mark;

        assign wipe = clr_en && (clr_tbl == TBL_W'(c));
        assign mark = set_en && (head == TBL_W'(c));

        // Clear first, then set, so a same-cycle set survives the clear.
        always_comb begin
            bits_d = bits_q;
            if (wipe) begin
                bits_d = '0;
            end
            if (mark) begin
                bits_d[set_reg] = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else begin
                bits_q <= bits_d;
            end
        end

        for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
            assign flags[r][c] = bits_q[r];
        end

        // R3: a clear with no set into the same column empties it.
        a_r3_column_wiped : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_tbl == TBL_W'(c) && !(set_en && head == TBL_W'(c)))
            |=> (bits_q == '0));

        // R9: clear and set on one column leave exactly the new flag.
        a_r9_set_after_clear : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_tbl == TBL_W'(c) && set_en && head == TBL_W'(c))
            |=> ($countones(bits_q) == 1 && bits_q[$past(set_reg)]));
    end

    // R2: a set request lands in the head column of its row.
    a_r2_set_lands : assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> flags[$past(set_reg)][$past(head)]);

    // R3: with no request the grid keeps its contents.
    a_r3_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(flags));

endmodule

// File: rtl/dfg_row_search.sv
module dfg_row_search
    import dfg_pkg::*;
#(
    parameter int NUM_TABLES = DEF_TABLES,
    localparam int TBL_W     = $clog2(NUM_TABLES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_TABLES-1:0]  row_i,
    input  logic [TBL_W-1:0]       head,
    input  logic [TBL_W-1:0]       tail,
    output logic                   hit_o,
    output logic [TBL_W-1:0]       tbl_o
);

    // Walk backward from head; the step count k is the age of a column.
    // The loop runs oldest first so the newest matching column wins.
    always_comb begin
        int span;
        int col;
        span  = window_span(int'(head), int'(tail), NUM_TABLES);
        hit_o = 1'b0;
        tbl_o = '0;
        for (int k = NUM_TABLES - 1; k >= 0; k--) begin
            col = (int'(head) + NUM_TABLES - k) % NUM_TABLES;
            if (k <= span && row_i[col]) begin
                hit_o = 1'b1;
                tbl_o = TBL_W'(col);
            end
        end
    end

    // R4: a reported table really holds a flag for this row.
    a_r4_hit_has_flag : assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> row_i[tbl_o]);

    // R6: a reported table lies in the circular window from tail to head.
    a_r6_hit_in_window : assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((head >= tail) ? (tbl_o <= head && tbl_o >= tail)
                                  : (tbl_o <= head || tbl_o >= tail)));

    // R7: an empty row never hits.
    a_r7_empty_row_misses : assert property (@(posedge clk) disable iff (!rst_n)
        (row_i == '0) |-> !hit_o);

endmodule

// File: rtl/dirty_flag_grid.sv
module dirty_flag_grid
    import dfg_pkg::*;
#(
    parameter int NUM_REGS    = DEF_REGS,
    parameter int NUM_TABLES  = DEF_TABLES,
    parameter int NUM_LOOKUPS = DEF_LOOKUPS,
    localparam int REG_W      = $clog2(NUM_REGS),
    localparam int TBL_W      = $clog2(NUM_TABLES)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [TBL_W-1:0]                      head,
    input  logic [TBL_W-1:0]                      tail,
    input  logic                                  clr_en,
    input  logic [TBL_W-1:0]                      clr_tbl,
    input  logic                                  set_en,
    input  logic [REG_W-1:0]                      set_reg,
    input  logic [NUM_LOOKUPS-1:0][REG_W-1:0]     lk_reg,
    output logic [NUM_LOOKUPS-1:0]                lk_hit,
    output logic [NUM_LOOKUPS-1:0][TBL_W-1:0]     lk_tbl
);

    logic [NUM_REGS-1:0][NUM_TABLES-1:0] flags;

    dfg_flag_store #(
        .NUM_REGS   (NUM_REGS),
        .NUM_TABLES (NUM_TABLES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .head    (head),
        .clr_en  (clr_en),
        .clr_tbl (clr_tbl),
        .set_en  (set_en),
        .set_reg (set_reg),
        .flags   (flags)
    );

    // R8: one independent search per lookup lane, all reading the pre-update grid (R10).
    for (genvar l = 0; l < NUM_LOOKUPS; l++) begin : g_lane
        dfg_row_search #(
            .NUM_TABLES (NUM_TABLES)
        ) u_search (
            .clk   (clk),
            .rst_n (rst_n),
            .row_i (flags[lk_reg[l]]),
            .head  (head),
            .tail  (tail),
            .hit_o (lk_hit[l]),
            .tbl_o (lk_tbl[l])
        );
    end

endmodule

// File: tb/tb_dirty_flag_grid.sv
module tb_dirty_flag_grid;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [1:0] hd;
        logic [1:0] tl;
        logic       s_en;
        logic [4:0] s_reg;
        logic       c_en;
        logic [1:0] c_tbl;
        logic [4:0] l0;
        logic [4:0] l1;
        logic [4:0] l2;
        logic [2:0] eh;   // bit n: lane n expected to hit
        logic [1:0] t0;
        logic [1:0] t1;
        logic [1:0] t2;
    } vec_t;

    // Expected values follow the requirements; lookups see pre-update flags.
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 2'd0, 1'b1, 5'd3, 1'b0, 2'd0, 5'd3, 5'd4, 5'd5, 3'b000, 2'd0, 2'd0, 2'd0},
        '{2'd0, 2'd0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd3, 5'd4, 5'd5, 3'b001, 2'd0, 2'd0, 2'd0},
        '{2'd1, 2'd0, 1'b1, 5'd4, 1'b1, 2'd1, 5'd3, 5'd4, 5'd5, 3'b001, 2'd0, 2'd0, 2'd0},
        '{2'd1, 2'd0, 1'b1, 5'd3, 1'b0, 2'd0, 5'd3, 5'd4, 5'd5, 3'b011, 2'd0, 2'd1, 2'd0},
        '{2'd1, 2'd0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd3, 5'd4, 5'd5, 3'b011, 2'd1, 2'd1, 2'd0},
        '{2'd2, 2'd0, 1'b1, 5'd5, 1'b1, 2'd2, 5'd3, 5'd4, 5'd5, 3'b011, 2'd1, 2'd1, 2'd0},
        '{2'd2, 2'd1, 1'b0, 5'd0, 1'b0, 2'd0, 5'd3, 5'd4, 5'd5, 3'b111, 2'd1, 2'd1, 2'd2},
        '{2'd2, 2'd2, 1'b0, 5'd0, 1'b0, 2'd0, 5'd3, 5'd4, 5'd5, 3'b100, 2'd0, 2'd0, 2'd2},
        '{2'd3, 2'd2, 1'b1, 5'd6, 1'b1, 2'd3, 5'd5, 5'd6, 5'd3, 3'b001, 2'd2, 2'd0, 2'd0},
        '{2'd0, 2'd2, 1'b1, 5'd7, 1'b1, 2'd0, 5'd6, 5'd5, 5'd3, 3'b111, 2'd3, 2'd2, 2'd0},
        '{2'd0, 2'd2, 1'b0, 5'd0, 1'b0, 2'd0, 5'd3, 5'd7, 5'd6, 3'b110, 2'd0, 2'd0, 2'd3},
        '{2'd0, 2'd2, 1'b1, 5'd6, 1'b0, 2'd0, 5'd6, 5'd5, 5'd4, 3'b011, 2'd3, 2'd2, 2'd0},
        '{2'd0, 2'd2, 1'b0, 5'd0, 1'b0, 2'd0, 5'd6, 5'd5, 5'd4, 3'b011, 2'd0, 2'd2, 2'd0}
    };

    localparam string VEC_REQ [NVEC] = '{
        "R7 R10", "R2 R8", "R10 R9", "R9 R2", "R4 R9", "R3 R10", "R6 R4",
        "R6 R7", "R7", "R5 R10", "R3 R5", "R10", "R5 R6"
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      head, tail, clr_tbl;
    logic            clr_en, set_en;
    logic [4:0]      set_reg;
    logic [2:0][4:0] lk_reg;
    logic [2:0]      lk_hit;
    logic [2:0][1:0] lk_tbl;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dirty_flag_grid dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .head    (head),
        .tail    (tail),
        .clr_en  (clr_en),
        .clr_tbl (clr_tbl),
        .set_en  (set_en),
        .set_reg (set_reg),
        .lk_reg  (lk_reg),
        .lk_hit  (lk_hit),
        .lk_tbl  (lk_tbl)
    );

    task automatic check_lane(input int lane, input logic eh, input logic [1:0] et,
                              input string req, input int vidx);
        checks++;
        if (lk_hit[lane] !== eh) begin
            fails++;
            $display("FAIL %s vec %0d lane %0d hit: got %0b expected %0b",
                     req, vidx, lane, lk_hit[lane], eh);
        end else if (eh) begin
            checks++;
            if (lk_tbl[lane] !== et) begin
                fails++;
                $display("FAIL %s vec %0d lane %0d table: got %0d expected %0d",
                         req, vidx, lane, lk_tbl[lane], et);
            end
        end
    endtask

    task automatic idle_inputs();
        set_en  = 1'b0;
        set_reg = '0;
        clr_en  = 1'b0;
        clr_tbl = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        head  = 2'd3;
        tail  = 2'd0;
        lk_reg = '{5'd0, 5'd31, 5'd3};
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: all lanes miss after reset with the whole grid active.
        for (int l = 0; l < 3; l++) begin
            check_lane(l, 1'b0, 2'd0, "R1", -1);
        end

        // Vector walk: drive at falling edge, sample 1 unit later.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            head    = VEC[v].hd;
            tail    = VEC[v].tl;
            set_en  = VEC[v].s_en;
            set_reg = VEC[v].s_reg;
            clr_en  = VEC[v].c_en;
            clr_tbl = VEC[v].c_tbl;
            lk_reg  = '{VEC[v].l2, VEC[v].l1, VEC[v].l0};
            #1;
            check_lane(0, VEC[v].eh[0], VEC[v].t0, VEC_REQ[v], v);
            check_lane(1, VEC[v].eh[1], VEC[v].t1, VEC_REQ[v], v);
            check_lane(2, VEC[v].eh[2], VEC[v].t2, VEC_REQ[v], v);
        end

        // R1: mid-run reset wipes flags that were hits a moment ago.
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        head   = 2'd0;
        tail   = 2'd1;
        lk_reg = '{5'd7, 5'd5, 5'd6};
        #1;
        for (int l = 0; l < 3; l++) begin
            check_lane(l, 1'b0, 2'd0, "R1", -2);
        end

        // R6: a flag in a column that falls out of the window is ignored.
        @(negedge clk);
        head    = 2'd3;
        tail    = 2'd3;
        set_en  = 1'b1;
        set_reg = 5'd31;
        @(negedge clk);
        idle_inputs();
        head   = 2'd2;
        tail   = 2'd0;
        lk_reg = '{5'd31, 5'd31, 5'd31};
        #1;
        check_lane(0, 1'b0, 2'd0, "R6", -3);
        @(negedge clk);
        head = 2'd3;
        #1;
        check_lane(1, 1'b1, 2'd3, "R6", -4);

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule